// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read side of a NOR-style memory device. A 16-bit read configuration word, written through a small register port, controls how reads behave. In asynchronous mode the block returns, combinationally, the word at the presented address from a small computed internal array. In synchronous mode it captures a start address on the clock edge where the address-valid strobe is sampled. It then counts out the programmed latency and streams words on the data bus. A data-valid flag marks each word, and a WAIT output with programmable polarity and lead time tells the host when data is not ready.

The configuration word sets the following:
- latency, from 2 to 7 clocks;
- one or two clocks per word;
- WAIT polarity, and whether WAIT deasserts together with the first word or one data cycle ahead of it;
- burst length of 4, 8 or 16 words, or continuous;
- for finite bursts, whether the address wraps inside the aligned block or runs on linearly.

Writes carrying a reserved code, or the unsupported latency/hold/lead combination, are refused and signalled with a one-cycle error pulse. Dropping chip enable ends any burst at once.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads 16'hBFCF: asynchronous mode (bit 15 = 1), latency code 7 (bits 13:11), WAIT active high (bit 10 = 1), two-clock hold (bit 9 = 1), early WAIT (bit 8 = 1), linear sequence (bit 7 = 1), rising edge (bit 6 = 1), no wrap (bit 3 = 1) and continuous length (bits 2:0 = 111). In this state dvalid_o and cfg_err_o are low and wait_o sits at its inactive level.
- R2: In asynchronous mode (bit 15 = 1), while ce_i is high, data_o equals {~a, a}, where a is addr_i[7:0]. The address-valid strobe has no effect in this mode, so dvalid_o stays low.
- R3: A write is refused, leaving the configuration unchanged, if it has any of the following: a latency code of 0 or 1; a length code outside {001, 010, 011, 111}; bit 7 equal to 0. A refused write drives cfg_err_o high for exactly the cycle after the write edge. Bits 14, 5 and 4 are stored as 0 whatever is written.
- R4: A write with latency code 2, bit 9 = 1 and bit 8 = 1 is refused with an error pulse. Latency code 2 with bit 9 = 1 and bit 8 = 0 is accepted.
- R5: In synchronous mode (bit 15 = 0), the first word of a burst is valid exactly L clock edges after the edge that samples adv_i high with ce_i high, where L is the latency code.
- R6: Each word stays on data_o with dvalid_o high for one clock when bit 9 = 0, and for two clocks when bit 9 = 1.
- R7: WAIT polarity follows bit 10: WAIT is asserted high when the bit is 1 and low when it is 0. Outside the latency phase wait_o is at the inactive level.
- R8: WAIT is asserted from the strobe edge until valid data. With bit 8 = 0 it deasserts in the cycle of the first word. With bit 8 = 1 it deasserts one data cycle (one or two clocks, per bit 9) earlier.
- R9: With bit 3 = 0 and a finite length N, word i of a burst starting at address s comes from (s & ~(N-1)) | ((s+i) & (N-1)).
- R10: With bit 3 = 1, or with continuous length, word i comes from s+i modulo the address space.
- R11: A finite burst ends after N words: dvalid_o goes low, data_o reads 0, and WAIT stays inactive until the next strobe.
- R12: Driving ce_i low forces dvalid_o low, data_o to 0 and WAIT inactive in the same cycle. The burst does not resume when ce_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Current configuration |
| cfg_err_o | output | 1 | One-cycle pulse on a refused write |
| ce_i | input | 1 | Chip enable, active high |
| adv_i | input | 1 | Address-valid strobe, active high |
| addr_i | input | AW | Read or burst start address |
| data_o | output | 16 | Read data |
| dvalid_o | output | 1 | Burst word valid |
| wait_o | output | 1 | WAIT, polarity per configuration |

## Verification
The bench targets the following corner cases:
- Latency 2 with early WAIT. A sequencer that counts latency one edge short or long shifts every word and desynchronises WAIT.
- Bursts that start mid-block with wrapping on. A design that wraps at the wrong boundary, or forgets to keep the upper address bits, reads the wrong words.
- A continuous burst whose wrap bit is clear, running through the top of the address space. A design that applies the wrap mask here stalls inside a block.
- Writes carrying the unsupported latency/hold/lead combination, reserved codes or set reserved bits. A lax register would store them, visible on readback and in later burst timing.
- An abort in the middle of a burst. A design that only stops at the next edge shows one stray valid word.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef struct packed {
    logic       async_mode;  // 15
    logic       rsv14;       // 14
    logic [2:0] lat;         // 13:11
    logic       wait_hi;     // 10
    logic       hold2;       // 9
    logic       wait_early;  // 8
    logic       seq_lin;     // 7
    logic       edge_rise;   // 6
    logic [1:0] rsv54;       // 5:4
    logic       no_wrap;     // 3
    logic [2:0] blen;        // 2:0
  } rcfg_t;

  localparam logic [15:0] RCFG_RST  = 16'hBFCF;
  localparam logic [15:0] RSV_MASK  = 16'h4030;
  localparam logic [2:0]  BLEN_CONT = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} seq_st_e;

  function automatic logic rcfg_ok(rcfg_t c);
    logic len_ok;
    len_ok = (c.blen == 3'b001) || (c.blen == 3'b010) ||
             (c.blen == 3'b011) || (c.blen == BLEN_CONT);
    return (c.lat >= 3'd2) && len_ok && c.seq_lin &&
           !((c.lat == 3'd2) && c.hold2 && c.wait_early);
  endfunction

  function automatic logic [15:0] array_word(logic [7:0] a);
    return {~a, a};
  endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output rcfg_t       cfg_o,
  output logic        err_o
);
  rcfg_t wr_cfg;
  logic  wr_ok;

  assign wr_cfg = rcfg_t'(wdata_i & ~RSV_MASK);
  assign wr_ok  = rcfg_ok(wr_cfg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= rcfg_t'(RCFG_RST);
      err_o <= 1'b0;
    end else begin
      if (we_i && wr_ok) cfg_o <= wr_cfg;
      err_o <= we_i && !wr_ok;
    end
  end

  AST_REJECT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_ok) |=> (err_o && $stable(cfg_o)));  // R3
  AST_ACCEPT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_ok) |=> !err_o);  // R3
  AST_NO_COMBO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((cfg_o.lat == 3'd2) && cfg_o.hold2 && cfg_o.wait_early));  // R4
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          wrap_en_i,
  input  logic [2:0]    blen_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] mask, addr_inc, addr_nxt;
  logic          wrap_act;

  always_comb begin
    unique case (blen_i)
      3'b001:  mask = AW'(3);
      3'b010:  mask = AW'(7);
      3'b011:  mask = AW'(15);
      default: mask = '0;
    endcase
  end

  assign wrap_act = wrap_en_i && (blen_i != BLEN_CONT);
  assign addr_inc = addr_o + 1'b1;
  assign addr_nxt = wrap_act ? ((addr_o & ~mask) | (addr_inc & mask)) : addr_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_addr_i;
    else if (step_i) addr_o <= addr_nxt;
  end

  AST_WRAP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && wrap_act) |=> ((addr_o & ~$past(mask)) == ($past(addr_o) & ~$past(mask))));  // R9
endmodule

// File: rtl/brs_seq_timer.sv
module brs_seq_timer
  import brs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       start_i,
  input  logic [2:0] lat_i,
  input  logic       hold2_i,
  input  logic       early_i,
  input  logic [2:0] blen_i,
  output logic       wait_act_o,
  output logic       dvalid_o,
  output logic       step_o
);
  seq_st_e    state_q;
  logic [2:0] cnt_q, lead;
  logic       hold_q, last_word;
  logic [3:0] wcnt_q, wlast;

  always_comb begin
    unique case (blen_i)
      3'b001:  wlast = 4'd3;
      3'b010:  wlast = 4'd7;
      default: wlast = 4'd15;
    endcase
  end

  assign lead      = early_i ? (hold2_i ? 3'd2 : 3'd1) : 3'd0;
  assign last_word = (blen_i != BLEN_CONT) && (wcnt_q == wlast);
  assign step_o    = (state_q == ST_DATA) && (!hold2_i || hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      wcnt_q  <= '0;
    end else if (!ce_i) begin
      state_q <= ST_IDLE;
    end else if (start_i) begin
      state_q <= ST_LAT;
      cnt_q   <= lat_i;
      hold_q  <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_LAT: begin
          if (cnt_q == 3'd1) state_q <= ST_DATA;
          else               cnt_q   <= cnt_q - 1'b1;
        end
        ST_DATA: begin
          if (step_o) begin
            hold_q <= 1'b0;
            wcnt_q <= wcnt_q + 1'b1;
            if (last_word) state_q <= ST_IDLE;
          end else begin
            hold_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dvalid_o   = ce_i && (state_q == ST_DATA);
  assign wait_act_o = ce_i && (state_q == ST_LAT) && (cnt_q > lead);

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (state_q == ST_IDLE));  // R12
  AST_START_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !dvalid_o);  // R5
  AST_HOLD_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && hold2_i && ce_i && !start_i && $stable(hold2_i)) |=> !step_o);  // R6
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [15:0]   cfg_wdata_i,
  output logic [15:0]   cfg_rdata_o,
  output logic          cfg_err_o,
  input  logic          ce_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  output logic [15:0]   data_o,
  output logic          dvalid_o,
  output logic          wait_o
);
  rcfg_t         cfg;
  logic          start, step, wait_act;
  logic [AW-1:0] cur_addr;

  brs_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .err_o   (cfg_err_o)
  );

  assign start = ce_i && adv_i && !cfg.async_mode;

  brs_addr_gen #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_addr_i (addr_i),
    .step_i      (step),
    .wrap_en_i   (!cfg.no_wrap),
    .blen_i      (cfg.blen),
    .addr_o      (cur_addr)
  );

  brs_seq_timer u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .start_i    (start),
    .lat_i      (cfg.lat),
    .hold2_i    (cfg.hold2),
    .early_i    (cfg.wait_early),
    .blen_i     (cfg.blen),
    .wait_act_o (wait_act),
    .dvalid_o   (dvalid_o),
    .step_o     (step)
  );

  assign cfg_rdata_o = 16'(cfg);
  assign wait_o      = cfg.wait_hi ? wait_act : !wait_act;

  always_comb begin
    if (!ce_i)               data_o = '0;
    else if (cfg.async_mode) data_o = array_word(8'(addr_i));
    else if (dvalid_o)       data_o = array_word(8'(cur_addr));
    else                     data_o = '0;
  end

  AST_VALID_NOT_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o |-> (wait_o == !cfg.wait_hi));  // R8
  AST_ASYNC_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.async_mode && $past(cfg.async_mode)) |-> !dvalid_o);  // R2
endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 1'b0, ce = 1'b0, adv = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  addr = '0;
  logic [15:0] cfg_rdata, data;
  logic        cfg_err, dvalid, wait_s;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  burst_read_seq #(.AW(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cfg_err_o(cfg_err), .ce_i(ce), .adv_i(adv),
    .addr_i(addr), .data_o(data), .dvalid_o(dvalid), .wait_o(wait_s)
  );

  // {cfg, start address, cycles observed}
  localparam logic [31:0] VEC [7] = '{
    {16'h14C1, 8'h06, 8'd10},
    {16'h1FCA, 8'h0D, 8'd22},
    {16'h39C3, 8'h2B, 8'd26},
    {16'h26C2, 8'hFE, 8'd23},
    {16'h2DC7, 8'hFC, 8'd30},
    {16'h15C9, 8'h03, 8'd10},
    {16'h33C1, 8'h11, 8'd17}
  };

  function automatic logic [15:0] wexp(logic [7:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v, output logic err);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    @(negedge clk); cfg_we = 1'b0; err = cfg_err;
  endtask

  task automatic run_burst(input logic [15:0] c, input logic [7:0] s, input int ncyc);
    logic e;
    int lc, h, lead, len, w;
    bit wrap, wa, ev;
    logic [7:0] ea;
    logic [15:0] ed;
    logic ew;
    write_cfg(c, e);
    chk(!e && cfg_rdata == c, "R3 burst cfg accepted", {15'd0, e, cfg_rdata}, {16'd0, c});
    lc   = int'(c[13:11]);
    h    = c[9] ? 2 : 1;
    lead = c[8] ? h : 0;
    len  = (c[2:0] == 3'b001) ? 4 : (c[2:0] == 3'b010) ? 8 : (c[2:0] == 3'b011) ? 16 : 0;
    wrap = !c[3] && (len != 0);
    ce = 1'b1; adv = 1'b1; addr = s;
    @(posedge clk);
    @(negedge clk); adv = 1'b0; addr = ~s;
    for (int j = 0; j < ncyc; j++) begin
      if (j > 0) begin @(posedge clk); @(negedge clk); end
      ea = '0; ev = 1'b0; wa = 1'b0;
      if (j < lc) begin
        wa = (lc - j) > lead;
      end else begin
        w = (j - lc) / h;
        if (len == 0 || w < len) begin
          ev = 1'b1;
          ea = wrap ? ((s & ~8'(len - 1)) | ((s + 8'(w)) & 8'(len - 1))) : s + 8'(w);
        end
      end
      ew = wa ? c[10] : !c[10];
      ed = ev ? wexp(ea) : 16'h0;
      // R5 R6 R7 R8 R9 R10 R11
      chk(dvalid == ev && wait_s == ew && data == ed, "R5/R6/R7/R8/R9/R10/R11 burst cycle",
          {14'd0, dvalid, wait_s, data}, {14'd0, ev, ew, ed});
    end
    @(negedge clk); ce = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [15:0] cur;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 16'hBFCF, "R1 reset cfg", {16'd0, cfg_rdata}, 32'h0000BFCF);
    chk(!dvalid && !cfg_err && wait_s == 1'b0, "R1 reset outputs",
        {29'd0, dvalid, cfg_err, wait_s}, 32'd0);

    // R2 asynchronous reads, strobe ignored
    ce = 1'b1; addr = 8'h37; #1;
    chk(data == wexp(8'h37), "R2 async word", {16'd0, data}, {16'd0, wexp(8'h37)});
    addr = 8'hC4; adv = 1'b1; #1;
    chk(data == wexp(8'hC4), "R2 async word 2", {16'd0, data}, {16'd0, wexp(8'hC4)});
    repeat (10) begin
      @(posedge clk); @(negedge clk);
      chk(!dvalid && wait_s == 1'b0, "R2 strobe ignored in async", {30'd0, dvalid, wait_s}, 32'd0);
    end
    adv = 1'b0; ce = 1'b0; #1;
    chk(data == 16'h0, "R12 ce low data idle", {16'd0, data}, 32'd0);

    // R3 refused writes keep config
    cur = cfg_rdata;
    write_cfg(16'h0DC7, e);
    chk(e && cfg_rdata == cur, "R3 latency code 1 refused", {15'd0, e, cfg_rdata}, {15'd0, 1'b1, cur});
    @(negedge clk);
    chk(!cfg_err, "R3 error is one pulse", {31'd0, cfg_err}, 32'd0);
    write_cfg(16'h14C4, e);
    chk(e && cfg_rdata == cur, "R3 length code 100 refused", {15'd0, e, cfg_rdata}, {15'd0, 1'b1, cur});
    write_cfg(16'h1441, e);
    chk(e && cfg_rdata == cur, "R3 sequence bit 0 refused", {15'd0, e, cfg_rdata}, {15'd0, 1'b1, cur});
    write_cfg(16'h54F1, e);
    chk(!e && cfg_rdata == 16'h14C1, "R3 reserved bits stored as 0", {15'd0, e, cfg_rdata}, 32'h000014C1);

    // R4 unsupported combination
    write_cfg(16'h17C1, e);
    chk(e && cfg_rdata == 16'h14C1, "R4 combo refused", {15'd0, e, cfg_rdata}, 32'h000114C1);
    write_cfg(16'h16C1, e);
    chk(!e && cfg_rdata == 16'h16C1, "R4 hold2 without early accepted", {15'd0, e, cfg_rdata}, 32'h000016C1);

    // table of bursts
    for (int i = 0; i < 7; i++) run_burst(VEC[i][31:16], VEC[i][15:8], int'(VEC[i][7:0]));

    // R12 abort mid-burst
    write_cfg(16'h1FCA, e);
    ce = 1'b1; adv = 1'b1; addr = 8'h20;
    @(posedge clk);
    @(negedge clk); adv = 1'b0;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    chk(dvalid && data == wexp(8'h20), "R12 burst running before abort",
        {15'd0, dvalid, data}, {15'd0, 1'b1, wexp(8'h20)});
    ce = 1'b0; #1;
    chk(!dvalid && data == 16'h0 && wait_s == 1'b0, "R12 abort same cycle",
        {14'd0, dvalid, wait_s, data}, 32'd0);
    @(posedge clk); @(negedge clk); ce = 1'b1;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(!dvalid && wait_s == 1'b0, "R12 no resume", {30'd0, dvalid, wait_s}, 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule